// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps the coherence state of every line in a data cache and decides which bus action each access needs. Processor accesses arrive with a line address, a read/write flag, a page-mode flag (copyback or write-through) and a mask of the long words they write. External accesses observed on the shared bus arrive as snoop requests with their own address, direction, a snoopable qualifier and a mark-invalid flag. For each access the controller asks for a line fill, issues a memory write, or inhibits memory and supplies the line to the other master. It also updates the per-line valid bit and the per-long-word dirty bits.

A line holds four 32-bit long words, so it is 16 bytes. Each long word has its own dirty bit. A line is invalid, valid (clean) or dirty, and it is dirty exactly when it is valid and at least one of its dirty bits is set. A small direct-mapped tag store is built in so the controller can be tested on its own. Data storage, arbitration and victim handling are left to the surrounding cache: an install overwrites whatever occupied the set. All addresses at the ports are line addresses. The low IDX_W bits select the set and the bits above them form the tag.

A snoop that is flagged snoopable takes precedence over a processor access offered in the same cycle. The processor access is simply held back for that cycle.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: A processor read that misses raises `fill_req_o` with `fill_line_o` equal to the requested line on the next cycle. Both are held until `fill_ack_i` is seen. In the cycle after the acknowledge, `proc_done_o` pulses, `fill_req_o` drops, and the line becomes valid with every dirty bit clear.
- R2: A copyback write that misses performs the same fill as R1. On the acknowledge the line is installed with its dirty bits equal to the write's long-word mask (`proc_lw_i` bit k marks long word k), which leaves the line dirty.
- R3: A write-through write that misses pulses `mem_wr_o` and `proc_done_o` on the next cycle, with `mem_wr_line_o` equal to the line and `mem_wr_lw_o` equal to the mask. It requests no fill and installs nothing.
- R4: A processor read that hits pulses `proc_done_o` on the next cycle with no fill and no memory write, and leaves the line state unchanged.
- R5: A write-through write that hits pulses `mem_wr_o` and `proc_done_o` as in R3 and leaves the line's valid bit and dirty bits unchanged.
- R6: A write-through write that hits a line with any dirty bit set also pulses `wt_err_o` in the same cycle as its `mem_wr_o`. In every other case `wt_err_o` stays low.
- R7: A copyback write that hits pulses `proc_done_o` on the next cycle with no bus request, and ORs its mask into the line's dirty bits.
- R8: A snoop that misses, a snoop write, and any request with `snp_snoopable_i` low leave `snp_inhibit_o` and `snp_source_o` low and change no line state.
- R9: A snoopable read that hits a clean line is ignored: no inhibit and no sourcing.
- R10: A snoopable read that hits a dirty line pulses `snp_inhibit_o` and `snp_source_o` on the next cycle. In that cycle `snp_src_line_o` is the line and `snp_src_lw_o` is its dirty-bit mask. Otherwise `snp_src_lw_o` is zero.
- R11: A snoopable read hit that carries `snp_mark_inv_i` invalidates the line, clean or dirty, at the edge that registers the snoop response. A later processor read of that line misses.
- R12: While a snoopable snoop request is present, `proc_ready_o` is low. A processor request is accepted only in a cycle with `proc_ready_o` high, and `proc_ready_o` is low while a fill is outstanding.
- R13: After reset every line is invalid, all pulse outputs and `fill_req_o` are low, and `proc_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_req_i | input | 1 | Processor access request |
| proc_wr_i | input | 1 | 1 = write, 0 = read |
| proc_cb_i | input | 1 | 1 = copyback page, 0 = write-through page |
| proc_line_i | input | LINE_W | Processor line address |
| proc_lw_i | input | LW | Long words written |
| proc_ready_o | output | 1 | Processor request accepted this cycle |
| proc_done_o | output | 1 | Access complete pulse |
| fill_req_o | output | 1 | Line fill request, held until acknowledged |
| fill_line_o | output | LINE_W | Line to fill |
| fill_ack_i | input | 1 | Fill data delivered |
| mem_wr_o | output | 1 | Memory write request pulse |
| mem_wr_line_o | output | LINE_W | Line of the memory write |
| mem_wr_lw_o | output | LW | Long words of the memory write |
| wt_err_o | output | 1 | Write-through write hit a dirty line |
| snp_req_i | input | 1 | Observed external access |
| snp_snoopable_i | input | 1 | External access is to be snooped |
| snp_wr_i | input | 1 | External access is a write |
| snp_mark_inv_i | input | 1 | Invalidate the line after a read hit |
| snp_line_i | input | LINE_W | External line address |
| snp_inhibit_o | output | 1 | Memory must not respond |
| snp_source_o | output | 1 | Cache supplies the line |
| snp_src_line_o | output | LINE_W | Line being supplied |
| snp_src_lw_o | output | LW | Dirty long words of the supplied line |

## Verification
A wrong valid bit or tag shows up at the next access to that set. A processor read that should hit raises a fill one cycle after acceptance, or a read that should miss completes without one. Corrupted dirty bits appear one cycle after the next snoopable read of the line, as a missing or extra inhibit or a wrong source mask. They can also appear as a wrong `wt_err_o` on a write-through hit. A lost invalidation, or an install that lands in the wrong set, surfaces only when that line is touched again. The bench therefore follows every state-changing operation with reads and snoops spread across the sets.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_VAL = 2'd1,
    LN_DRT = 2'd2
  } line_st_e;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_FILL = 1'b1
  } proc_st_e;

  function automatic line_st_e line_state(input logic vld, input logic any_dirty);
    if (!vld)           return LN_INV;
    else if (any_dirty) return LN_DRT;
    else                return LN_VAL;
  endfunction

endpackage

// File: rtl/coh_tag_store.sv
module coh_tag_store #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8,
  parameter int LW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] p_idx,
  output logic             p_vld,
  output logic [TAG_W-1:0] p_tag,
  output logic [LW-1:0]    p_db,
  input  logic [IDX_W-1:0] s_idx,
  output logic             s_vld,
  output logic [TAG_W-1:0] s_tag,
  output logic [LW-1:0]    s_db,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [LW-1:0]    wr_db,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);

  logic [TAG_W-1:0] tag_mem [SETS];
  logic [LW-1:0]    db_mem  [SETS];
  logic [SETS-1:0]  vld_q;

  // tag and dirty arrays: one write port, no reset (RAM friendly)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      db_mem[wr_idx]  <= wr_db;
    end
  end

  // valid bits: install wins over a same-cycle snoop invalidation
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (inv_en) vld_q[inv_idx] <= 1'b0;
      if (wr_en)  vld_q[wr_idx]  <= 1'b1;
    end
  end

  assign p_vld = vld_q[p_idx];
  assign p_tag = tag_mem[p_idx];
  assign p_db  = db_mem[p_idx];
  assign s_vld = vld_q[s_idx];
  assign s_tag = tag_mem[s_idx];
  assign s_db  = db_mem[s_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit #(
  parameter int LINE_W = 12,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int LW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_req_i,
  input  logic              snp_snoopable_i,
  input  logic              snp_wr_i,
  input  logic              snp_mark_inv_i,
  input  logic [LINE_W-1:0] snp_line_i,
  input  logic              s_vld,
  input  logic [TAG_W-1:0]  s_tag,
  input  logic [LW-1:0]     s_db,
  output logic              snp_active,
  output logic              inv_en,
  output logic              inhibit_o,
  output logic              source_o,
  output logic [LINE_W-1:0] src_line_o,
  output logic [LW-1:0]     src_lw_o
);
  import coh_pkg::*;

  logic     rd_hit;
  line_st_e s_state;

  assign snp_active = snp_req_i && snp_snoopable_i;
  assign s_state    = line_state(s_vld && (s_tag == snp_line_i[LINE_W-1:IDX_W]), |s_db);
  assign rd_hit     = snp_active && !snp_wr_i && (s_state != LN_INV);
  assign inv_en     = rd_hit && snp_mark_inv_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      inhibit_o  <= 1'b0;
      source_o   <= 1'b0;
      src_line_o <= '0;
      src_lw_o   <= '0;
    end else begin
      inhibit_o  <= rd_hit && (s_state == LN_DRT);
      source_o   <= rd_hit && (s_state == LN_DRT);
      src_line_o <= snp_line_i;
      src_lw_o   <= (rd_hit && (s_state == LN_DRT)) ? s_db : '0;
    end
  end

endmodule

// File: rtl/coh_proc_ctrl.sv
module coh_proc_ctrl #(
  parameter int LINE_W = 12,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int LW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_req_i,
  input  logic              proc_wr_i,
  input  logic              proc_cb_i,
  input  logic [LINE_W-1:0] proc_line_i,
  input  logic [LW-1:0]     proc_lw_i,
  input  logic              snp_active,
  input  logic              fill_ack_i,
  input  logic              p_vld,
  input  logic [TAG_W-1:0]  p_tag,
  input  logic [LW-1:0]     p_db,
  output logic              ready_o,
  output logic              done_o,
  output logic              fill_req_o,
  output logic [LINE_W-1:0] pend_line_o,
  output logic              mem_wr_o,
  output logic [LW-1:0]     pend_lw_o,
  output logic              wt_err_o,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [LW-1:0]     wr_db
);
  import coh_pkg::*;

  proc_st_e          st_q;
  logic              pend_wr_q;
  logic              accept, hit;

  assign ready_o = (st_q == PS_IDLE) && !snp_active;
  assign accept  = ready_o && proc_req_i;
  assign hit     = p_vld && (p_tag == proc_line_i[LINE_W-1:IDX_W]);

  // tag store write: copyback hit merge, or fill install
  always_comb begin
    wr_en  = 1'b0;
    wr_idx = proc_line_i[IDX_W-1:0];
    wr_tag = proc_line_i[LINE_W-1:IDX_W];
    wr_db  = p_db | proc_lw_i;
    if (st_q == PS_FILL) begin
      wr_en  = fill_ack_i;
      wr_idx = pend_line_o[IDX_W-1:0];
      wr_tag = pend_line_o[LINE_W-1:IDX_W];
      wr_db  = pend_wr_q ? pend_lw_o : '0;
    end else if (accept && proc_wr_i && proc_cb_i && hit) begin
      wr_en  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= PS_IDLE;
      pend_wr_q   <= 1'b0;
      pend_line_o <= '0;
      pend_lw_o   <= '0;
      fill_req_o  <= 1'b0;
      done_o      <= 1'b0;
      mem_wr_o    <= 1'b0;
      wt_err_o    <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      mem_wr_o <= 1'b0;
      wt_err_o <= 1'b0;
      case (st_q)
        PS_IDLE: begin
          if (accept) begin
            pend_line_o <= proc_line_i;
            pend_lw_o   <= proc_lw_i;
            pend_wr_q   <= proc_wr_i;
            if (proc_wr_i && !proc_cb_i) begin
              mem_wr_o <= 1'b1;
              done_o   <= 1'b1;
              wt_err_o <= hit && (|p_db);
            end else if (hit) begin
              done_o <= 1'b1;
            end else begin
              fill_req_o <= 1'b1;
              st_q       <= PS_FILL;
            end
          end
        end
        PS_FILL: begin
          if (fill_ack_i) begin
            fill_req_o <= 1'b0;
            done_o     <= 1'b1;
            st_q       <= PS_IDLE;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int SETS    = 16,
  parameter int LW      = 4,
  parameter int LW_BYTES = 4,
  localparam int OFF_W  = $clog2(LW * LW_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_req_i,
  input  logic              proc_wr_i,
  input  logic              proc_cb_i,
  input  logic [LINE_W-1:0] proc_line_i,
  input  logic [LW-1:0]     proc_lw_i,
  output logic              proc_ready_o,
  output logic              proc_done_o,
  output logic              fill_req_o,
  output logic [LINE_W-1:0] fill_line_o,
  input  logic              fill_ack_i,
  output logic              mem_wr_o,
  output logic [LINE_W-1:0] mem_wr_line_o,
  output logic [LW-1:0]     mem_wr_lw_o,
  output logic              wt_err_o,
  input  logic              snp_req_i,
  input  logic              snp_snoopable_i,
  input  logic              snp_wr_i,
  input  logic              snp_mark_inv_i,
  input  logic [LINE_W-1:0] snp_line_i,
  output logic              snp_inhibit_o,
  output logic              snp_source_o,
  output logic [LINE_W-1:0] snp_src_line_o,
  output logic [LW-1:0]     snp_src_lw_o
);

  logic             p_vld, s_vld, snp_active;
  logic [TAG_W-1:0] p_tag, s_tag;
  logic [LW-1:0]    p_db, s_db;
  logic             wr_en, inv_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [LW-1:0]    wr_db;
  logic [LINE_W-1:0] pend_line;
  logic [LW-1:0]     pend_lw;

  coh_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LW(LW)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .p_idx   (proc_line_i[IDX_W-1:0]),
    .p_vld   (p_vld),
    .p_tag   (p_tag),
    .p_db    (p_db),
    .s_idx   (snp_line_i[IDX_W-1:0]),
    .s_vld   (s_vld),
    .s_tag   (s_tag),
    .s_db    (s_db),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .wr_db   (wr_db),
    .inv_en  (inv_en),
    .inv_idx (snp_line_i[IDX_W-1:0])
  );

  coh_snoop_unit #(.LINE_W(LINE_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .LW(LW)) u_snoop (
    .clk             (clk),
    .rst             (rst),
    .snp_req_i       (snp_req_i),
    .snp_snoopable_i (snp_snoopable_i),
    .snp_wr_i        (snp_wr_i),
    .snp_mark_inv_i  (snp_mark_inv_i),
    .snp_line_i      (snp_line_i),
    .s_vld           (s_vld),
    .s_tag           (s_tag),
    .s_db            (s_db),
    .snp_active      (snp_active),
    .inv_en          (inv_en),
    .inhibit_o       (snp_inhibit_o),
    .source_o        (snp_source_o),
    .src_line_o      (snp_src_line_o),
    .src_lw_o        (snp_src_lw_o)
  );

  coh_proc_ctrl #(.LINE_W(LINE_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .LW(LW)) u_proc (
    .clk         (clk),
    .rst         (rst),
    .proc_req_i  (proc_req_i),
    .proc_wr_i   (proc_wr_i),
    .proc_cb_i   (proc_cb_i),
    .proc_line_i (proc_line_i),
    .proc_lw_i   (proc_lw_i),
    .snp_active  (snp_active),
    .fill_ack_i  (fill_ack_i),
    .p_vld       (p_vld),
    .p_tag       (p_tag),
    .p_db        (p_db),
    .ready_o     (proc_ready_o),
    .done_o      (proc_done_o),
    .fill_req_o  (fill_req_o),
    .pend_line_o (pend_line),
    .mem_wr_o    (mem_wr_o),
    .pend_lw_o   (pend_lw),
    .wt_err_o    (wt_err_o),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_tag      (wr_tag),
    .wr_db       (wr_db)
  );

  assign fill_line_o   = pend_line;
  assign mem_wr_line_o = pend_line;
  assign mem_wr_lw_o   = pend_lw;

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_req_i,
  input logic              proc_wr_i,
  input logic              proc_cb_i,
  input logic              proc_ready_o,
  input logic              fill_req_o,
  input logic [LINE_W-1:0] fill_line_o,
  input logic              fill_ack_i,
  input logic              mem_wr_o,
  input logic              wt_err_o,
  input logic              snp_req_i,
  input logic              snp_snoopable_i,
  input logic              snp_wr_i,
  input logic              snp_inhibit_o
);

  assert_fill_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (fill_req_o && !fill_ack_i) |=> (fill_req_o && $stable(fill_line_o)));

  assert_no_accept_in_fill_R12: assert property (@(posedge clk) disable iff (rst)
    fill_req_o |-> !proc_ready_o);

  assert_snoop_priority_R12: assert property (@(posedge clk) disable iff (rst)
    (snp_req_i && snp_snoopable_i) |-> !proc_ready_o);

  assert_mem_wr_cause_R3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> $past(proc_req_i && proc_wr_i && !proc_cb_i && proc_ready_o));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    wt_err_o |-> $past(proc_req_i && proc_wr_i && !proc_cb_i));

  assert_inhibit_cause_R8: assert property (@(posedge clk) disable iff (rst)
    snp_inhibit_o |-> $past(snp_req_i && snp_snoopable_i && !snp_wr_i));

endmodule

bind snoop_coh_ctrl coh_checker #(.LINE_W(LINE_W)) u_coh_checker (
  .clk             (clk),
  .rst             (rst),
  .proc_req_i      (proc_req_i),
  .proc_wr_i       (proc_wr_i),
  .proc_cb_i       (proc_cb_i),
  .proc_ready_o    (proc_ready_o),
  .fill_req_o      (fill_req_o),
  .fill_line_o     (fill_line_o),
  .fill_ack_i      (fill_ack_i),
  .mem_wr_o        (mem_wr_o),
  .wt_err_o        (wt_err_o),
  .snp_req_i       (snp_req_i),
  .snp_snoopable_i (snp_snoopable_i),
  .snp_wr_i        (snp_wr_i),
  .snp_inhibit_o   (snp_inhibit_o)
);

// File: tb/tb_snoop_coh_ctrl.sv
`timescale 1ns/1ps
module tb_snoop_coh_ctrl;

  localparam int LINE_W = 12;
  localparam int LW     = 4;
  localparam int SETS   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              proc_req_i = 0, proc_wr_i = 0, proc_cb_i = 0;
  logic [LINE_W-1:0] proc_line_i = '0;
  logic [LW-1:0]     proc_lw_i = '0;
  logic              proc_ready_o, proc_done_o, fill_req_o, fill_ack_i = 0;
  logic [LINE_W-1:0] fill_line_o, mem_wr_line_o, snp_src_line_o;
  logic              mem_wr_o, wt_err_o;
  logic [LW-1:0]     mem_wr_lw_o, snp_src_lw_o;
  logic              snp_req_i = 0, snp_snoopable_i = 0, snp_wr_i = 0, snp_mark_inv_i = 0;
  logic [LINE_W-1:0] snp_line_i = '0;
  logic              snp_inhibit_o, snp_source_o;

  snoop_coh_ctrl dut (.*);

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  logic         m_vld [SETS];
  logic [7:0]   m_tag [SETS];
  logic [LW-1:0] m_db [SETS];

  function automatic logic m_hit(input logic [LINE_W-1:0] ln);
    return m_vld[ln[3:0]] && (m_tag[ln[3:0]] == ln[11:4]);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic proc_op(input logic wr, input logic cb, input logic [LINE_W-1:0] ln, input logic [LW-1:0] lw);
    logic h;
    logic [LW-1:0] db;
    h  = m_hit(ln);
    db = m_db[ln[3:0]];
    @(negedge clk);
    proc_req_i = 1; proc_wr_i = wr; proc_cb_i = cb; proc_line_i = ln; proc_lw_i = lw;
    #1 chk(proc_ready_o == 1'b1, "R12 ready when idle", 32'(proc_ready_o), 1);
    @(negedge clk);
    proc_req_i = 0;
    if (wr && !cb) begin
      chk(mem_wr_o == 1'b1 && mem_wr_line_o == ln && mem_wr_lw_o == lw, h ? "R5 wt hit mem write" : "R3 wt miss mem write",
          {mem_wr_o, 3'b0, mem_wr_lw_o, 4'b0, mem_wr_line_o}, {1'b1, 3'b0, lw, 4'b0, ln});
      chk(proc_done_o == 1'b1 && fill_req_o == 1'b0, "R3 done no fill", {proc_done_o, fill_req_o}, 2'b10);
      chk(wt_err_o == (h && |db), "R6 wt error flag", 32'(wt_err_o), 32'(h && |db));
    end else if (h) begin
      chk(proc_done_o == 1'b1 && fill_req_o == 1'b0 && mem_wr_o == 1'b0, wr ? "R7 cb hit no bus" : "R4 read hit no bus",
          {proc_done_o, fill_req_o, mem_wr_o}, 3'b100);
      if (wr) m_db[ln[3:0]] = db | lw;
    end else begin
      chk(fill_req_o == 1'b1 && fill_line_o == ln && proc_done_o == 1'b0, wr ? "R2 cb miss fill" : "R1 read miss fill",
          {fill_req_o, 3'b0, fill_line_o}, {1'b1, 3'b0, ln});
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(fill_req_o == 1'b1 && fill_line_o == ln, "R1 fill held", 32'(fill_req_o), 1);
      end
      fill_ack_i = 1;
      @(negedge clk);
      fill_ack_i = 0;
      chk(proc_done_o == 1'b1 && fill_req_o == 1'b0, "R1 fill done", {proc_done_o, fill_req_o}, 2'b10);
      m_vld[ln[3:0]] = 1;
      m_tag[ln[3:0]] = ln[11:4];
      m_db[ln[3:0]]  = wr ? lw : '0;
    end
  endtask

  task automatic snoop_drive(input logic wr, input logic sn, input logic mi, input logic [LINE_W-1:0] ln);
    snp_req_i = 1; snp_wr_i = wr; snp_snoopable_i = sn; snp_mark_inv_i = mi; snp_line_i = ln;
  endtask

  // expected snoop response, checked one negedge after drive; updates model
  task automatic snoop_check(input logic wr, input logic sn, input logic mi, input logic [LINE_W-1:0] ln,
                             input logic h, input logic [LW-1:0] db);
    logic inh;
    inh = sn && !wr && h && |db;
    chk(snp_inhibit_o == inh && snp_source_o == inh,
        !sn || wr || !h ? "R8 no snoop effect" : (inh ? "R10 dirty intervene" : "R9 clean ignored"),
        {snp_inhibit_o, snp_source_o}, {inh, inh});
    chk(snp_src_lw_o == (inh ? db : '0) && (!inh || snp_src_line_o == ln), "R10 source line and mask",
        {snp_src_lw_o, snp_src_line_o}, {(inh ? db : 4'h0), ln});
    if (sn && !wr && h && mi) m_vld[ln[3:0]] = 0;
  endtask

  task automatic snoop_op(input logic wr, input logic sn, input logic mi, input logic [LINE_W-1:0] ln);
    logic h;
    logic [LW-1:0] db;
    h  = m_hit(ln);
    db = m_db[ln[3:0]];
    @(negedge clk);
    snoop_drive(wr, sn, mi, ln);
    @(negedge clk);
    snp_req_i = 0; snp_snoopable_i = 0;
    snoop_check(wr, sn, mi, ln, h, db);
  endtask

  function automatic logic [LINE_W-1:0] rnd_line();
    return {8'($urandom % 2), 4'($urandom % 4)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < SETS; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_db[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R13 reset state
    chk(proc_ready_o && !proc_done_o && !fill_req_o && !mem_wr_o && !wt_err_o && !snp_inhibit_o && !snp_source_o,
        "R13 reset outputs", {proc_ready_o, proc_done_o, fill_req_o, mem_wr_o, wt_err_o, snp_inhibit_o},
        6'b100000);
    proc_op(0, 0, 12'h013, 4'h0);          // R1 read miss (after reset all invalid)
    proc_op(0, 0, 12'h013, 4'h0);          // R4 read hit
    snoop_op(0, 1, 0, 12'h013);            // R9 clean read hit ignored
    proc_op(1, 1, 12'h025, 4'b0101);       // R2 copyback write miss
    snoop_op(0, 1, 0, 12'h025);            // R10 intervene, mask 0101
    proc_op(1, 0, 12'h025, 4'b1000);       // R6 wt hit on dirty line, R5 bits unchanged
    snoop_op(0, 1, 0, 12'h025);            // R5 mask still 0101
    proc_op(1, 1, 12'h025, 4'b0010);       // R7 cb hit merge -> 0111
    snoop_op(0, 0, 0, 12'h025);            // R8 not snoopable
    snoop_op(1, 1, 1, 12'h025);            // R8 snoop write with mark invalid ignored
    snoop_op(0, 1, 0, 12'h125);            // R8 snoop miss (other tag)
    snoop_op(0, 1, 1, 12'h025);            // R11 dirty + mark invalid
    proc_op(0, 0, 12'h025, 4'h0);          // R11 now misses
    proc_op(1, 0, 12'h037, 4'b0011);       // R3 wt miss no allocate
    proc_op(0, 0, 12'h037, 4'h0);          // R3 read still misses
    snoop_op(0, 1, 1, 12'h037);            // R11 clean + mark invalid
    proc_op(0, 0, 12'h037, 4'h0);          // R11 read misses again

    // R12 snoop wins over a same-cycle processor request
    proc_op(1, 1, 12'h042, 4'b1001);
    @(negedge clk);
    snoop_drive(0, 1, 0, 12'h042);
    proc_req_i = 1; proc_wr_i = 0; proc_cb_i = 0; proc_line_i = 12'h013; proc_lw_i = 0;
    #1 chk(proc_ready_o == 1'b0, "R12 snoop priority", 32'(proc_ready_o), 0);
    @(negedge clk);
    snp_req_i = 0; snp_snoopable_i = 0;
    snoop_check(0, 1, 0, 12'h042, 1'b1, 4'b1001);
    chk(proc_done_o == 1'b0, "R12 held access not done", 32'(proc_done_o), 0);
    #1 chk(proc_ready_o == 1'b1, "R12 accepted after snoop", 32'(proc_ready_o), 1);
    @(negedge clk);
    proc_req_i = 0;
    chk(proc_done_o == 1'b1 && fill_req_o == 1'b0, "R12 held read hit done", {proc_done_o, fill_req_o}, 2'b10);

    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom % 8;
      if (sel < 5) proc_op(1'($urandom % 2), 1'($urandom % 2), rnd_line(), 4'($urandom % 16));
      else         snoop_op(1'($urandom % 4 == 0), 1'($urandom % 5 != 0), 1'($urandom % 3 == 0), rnd_line());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule